// File: doc/BRIEF.md
# Self-Nesting Interrupt Event Controller

This block decides which of a set of prioritized interrupt levels a processor core services next. It keeps the return address that the core needs when a handler ends. A level becomes eligible once it is raised and its mask bit is set. The block then compares it with the level the core is already running at. When the level wins, the block issues a vector fetch address from a table of handler words and moves the level from the latched-request set into the pending set.

A configuration bit lets a handler re-enter its own level. The entry is then recorded by setting bit 0 of the saved return address. A later return that finds this marker leaves the level pending and resumes at the even address. Software saves the marker-carrying address before nesting and writes it back through the return-address port before each return.

The control is a three-state machine. ST_WAIT arbitrates every cycle. The transition TAKE (an eligible level wins) goes to ST_ENTER. The transition LEAVE (return strobe while a level is pending, and no level wins) goes to ST_EXIT. ST_ENTER and ST_EXIT each last one cycle and take the transition DONE back to ST_WAIT.

Top module: `evt_nest_ctrl`

## Requirements
- R1: After reset the latched, pending and mask bits are all zero, self-nesting is off, the saved return address is zero, and both vec_valid and resume_valid are low.
- R2: A raise pulse sets the bit of that level in `latched` one cycle later. A level whose mask bit is clear never produces a vector and stays latched.
- R3: When several unmasked levels are latched, the lowest-numbered one is vectored first. A higher-numbered one stays latched until a return drops the core below its priority.
- R4: A vector is a single-cycle vec_valid pulse with vec_addr equal to VEC_BASE plus 4 times the level number. The pulse appears two clock edges after the raise edge when the level wins at once.
- R5: In the cycle vec_valid is high, the bit of the vectored level is set in `pending` and cleared in `latched`.
- R6: A vector taken from user level or from a lower priority loads the saved return address with cur_pc, with bit 0 cleared.
- R7: With self-nesting on, raising the active level vectors to that level again. The pending bit stays set, and the saved return address holds cur_pc with bit 0 set.
- R8: With self-nesting off, raising the active level only latches it. It is vectored again only after the current handler returns, and that entry records bit 0 clear.
- R9: A return strobe whose saved address has bit 0 clear gives a one-cycle resume_valid pulse one edge later. It clears the pending bit of the current (lowest pending) level, and resume_addr equals the saved address.
- R10: A return strobe whose saved address has bit 0 set leaves the pending set unchanged. Resume_addr equals the saved address with bit 0 cleared.
- R11: A return strobe while nothing is pending gives no resume pulse and changes no pending bit.
- R12: A lower-numbered level preempts an active higher-numbered one even with self-nesting on. The entry records bit 0 clear, and both levels stay pending until the return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raise_req | input | NUM_LVL | Per-level raise pulses, bit index = level |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | NUM_LVL | New mask, bit index = level, 1 = enabled |
| cfg_we | input | 1 | Self-nesting configuration write strobe |
| cfg_nest | input | 1 | Written value of the self-nesting enable |
| cur_pc | input | ADDR_W | Address of the instruction an entry interrupts |
| rti | input | 1 | Return-from-interrupt strobe |
| ret_we | input | 1 | Saved return address write strobe |
| ret_wdata | input | ADDR_W | Value written to the saved return address |
| latched | output | NUM_LVL | Latched-request register |
| pending | output | NUM_LVL | Pending-level register |
| vec_valid | output | 1 | One-cycle vector fetch pulse |
| vec_addr | output | ADDR_W | Handler table entry address of the vectored level |
| ret_addr | output | ADDR_W | Saved return address, bit 0 = same-level nesting marker |
| resume_valid | output | 1 | One-cycle return pulse |
| resume_addr | output | ADDR_W | Address execution resumes at |

## Verification
The bench builds the block with eight levels and a table base of 0x100. With eight levels it can visit every ordered pair of levels for the priority and deferral rules, and every single level for three-deep self-nesting and for blocked self-raising. Expected vector addresses and resume addresses are computed as base plus four times the level and from per-case program-counter values. Masked-level starvation, preemption under nesting, a hand-written marked return and a return with nothing pending are run as directed cases.

// File: rtl/evt_nest_pkg.sv
package evt_nest_pkg;
    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_ENTER = 2'd1,
        ST_EXIT  = 2'd2
    } evt_state_e;
endpackage

// File: rtl/evt_lowest_set.sv
module evt_lowest_set #(
    parameter int N  = 16,
    parameter int IW = 4
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          found
);
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx   = IW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/evt_arbiter.sv
module evt_arbiter #(
    parameter int NUM_LVL = 16,
    localparam int LVL_W  = $clog2(NUM_LVL)
) (
    input  logic [NUM_LVL-1:0] latched,
    input  logic [NUM_LVL-1:0] mask,
    input  logic [NUM_LVL-1:0] pending,
    input  logic               nest_en,
    output logic               take,
    output logic [LVL_W-1:0]   take_lvl,
    output logic               self_entry,
    output logic               cur_any,
    output logic [LVL_W-1:0]   cur_lvl
);
    logic [NUM_LVL-1:0] eligible;
    logic               cand_any;

    assign eligible = latched & mask;

    evt_lowest_set #(.N(NUM_LVL), .IW(LVL_W)) u_cand (
        .vec   (eligible),
        .idx   (take_lvl),
        .found (cand_any)
    );

    evt_lowest_set #(.N(NUM_LVL), .IW(LVL_W)) u_cur (
        .vec   (pending),
        .idx   (cur_lvl),
        .found (cur_any)
    );

    always_comb begin
        self_entry = cand_any && cur_any && (take_lvl == cur_lvl) && nest_en;
        take       = cand_any && (!cur_any || (take_lvl < cur_lvl) || self_entry);
    end
endmodule

// File: rtl/evt_vec_table.sv
module evt_vec_table #(
    parameter int                  NUM_LVL  = 16,
    parameter int                  ADDR_W   = 32,
    parameter logic [ADDR_W-1:0]   VEC_BASE = 'h2000,
    localparam int                 LVL_W    = $clog2(NUM_LVL)
) (
    input  logic [LVL_W-1:0]  lvl,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] entry [NUM_LVL];

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_entry
        assign entry[g] = VEC_BASE + ADDR_W'(4 * g);
    end

    assign addr = entry[lvl];
endmodule

// File: rtl/evt_nest_ctrl.sv
module evt_nest_ctrl
    import evt_nest_pkg::*;
#(
    parameter int                NUM_LVL  = 16,
    parameter int                ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] VEC_BASE = 'h2000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] raise_req,
    input  logic               mask_we,
    input  logic [NUM_LVL-1:0] mask_wdata,
    input  logic               cfg_we,
    input  logic               cfg_nest,
    input  logic [ADDR_W-1:0]  cur_pc,
    input  logic               rti,
    input  logic               ret_we,
    input  logic [ADDR_W-1:0]  ret_wdata,
    output logic [NUM_LVL-1:0] latched,
    output logic [NUM_LVL-1:0] pending,
    output logic               vec_valid,
    output logic [ADDR_W-1:0]  vec_addr,
    output logic [ADDR_W-1:0]  ret_addr,
    output logic               resume_valid,
    output logic [ADDR_W-1:0]  resume_addr
);
    localparam int                LVL_W   = $clog2(NUM_LVL);
    localparam logic [ADDR_W-1:0] LSB_CLR = {{(ADDR_W-1){1'b1}}, 1'b0};

    evt_state_e         state_q, state_d;
    logic [NUM_LVL-1:0] latched_q, pending_q, mask_q;
    logic               nest_q;
    logic [ADDR_W-1:0]  ret_q, vec_addr_q, resume_q;

    logic               take, self_entry, cur_any;
    logic [LVL_W-1:0]   take_lvl, cur_lvl;
    logic [ADDR_W-1:0]  tbl_addr;
    logic               go_enter, go_exit;
    logic [NUM_LVL-1:0] take_bit, cur_bit;

    evt_arbiter #(.NUM_LVL(NUM_LVL)) u_arb (
        .latched    (latched_q),
        .mask       (mask_q),
        .pending    (pending_q),
        .nest_en    (nest_q),
        .take       (take),
        .take_lvl   (take_lvl),
        .self_entry (self_entry),
        .cur_any    (cur_any),
        .cur_lvl    (cur_lvl)
    );

    evt_vec_table #(.NUM_LVL(NUM_LVL), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_tbl (
        .lvl  (take_lvl),
        .addr (tbl_addr)
    );

    assign go_enter = (state_q == ST_WAIT) && take;
    assign go_exit  = (state_q == ST_WAIT) && !take && rti && cur_any;
    assign take_bit = NUM_LVL'(1) << take_lvl;
    assign cur_bit  = NUM_LVL'(1) << cur_lvl;

    // next-state logic: TAKE, LEAVE, DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: begin
                if (go_enter)     state_d = ST_ENTER;
                else if (go_exit) state_d = ST_EXIT;
            end
            ST_ENTER: state_d = ST_WAIT;
            ST_EXIT:  state_d = ST_WAIT;
            default:  state_d = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    // level, configuration and address registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latched_q  <= '0;
            pending_q  <= '0;
            mask_q     <= '0;
            nest_q     <= 1'b0;
            ret_q      <= '0;
            vec_addr_q <= '0;
            resume_q   <= '0;
        end else begin
            latched_q <= (latched_q & ~(go_enter ? take_bit : '0)) | raise_req;
            if (mask_we) mask_q <= mask_wdata;
            if (cfg_we)  nest_q <= cfg_nest;
            if (go_enter) begin
                pending_q  <= pending_q | take_bit;
                vec_addr_q <= tbl_addr;
                ret_q      <= (cur_pc & LSB_CLR) | ADDR_W'(self_entry);
            end else begin
                if (ret_we) ret_q <= ret_wdata;
                if (go_exit) begin
                    resume_q <= ret_q & LSB_CLR;
                    if (!ret_q[0]) pending_q <= pending_q & ~cur_bit;
                end
            end
        end
    end

    // outputs
    always_comb begin
        vec_valid    = (state_q == ST_ENTER);
        resume_valid = (state_q == ST_EXIT);
        vec_addr     = vec_addr_q;
        resume_addr  = resume_q;
        ret_addr     = ret_q;
        latched      = latched_q;
        pending      = pending_q;
    end
endmodule

// File: rtl/evt_nest_ctrl_chk.sv
module evt_nest_ctrl_chk #(
    parameter int                NUM_LVL  = 16,
    parameter int                ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] VEC_BASE = 'h2000
) (
    input logic               clk,
    input logic               rst_n,
    input logic               vec_valid,
    input logic [ADDR_W-1:0]  vec_addr,
    input logic [NUM_LVL-1:0] pending,
    input logic [NUM_LVL-1:0] mask_q,
    input logic               nest_q,
    input logic [ADDR_W-1:0]  ret_addr,
    input logic               resume_valid,
    input logic [ADDR_W-1:0]  resume_addr
);
    logic known, pend_hit, mask_hit;

    always_comb begin
        known    = 1'b0;
        pend_hit = 1'b0;
        mask_hit = 1'b0;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (vec_addr == VEC_BASE + ADDR_W'(4 * i)) begin
                known    = 1'b1;
                pend_hit = pending[i];
                mask_hit = mask_q[i];
            end
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pending == '0) && !vec_valid && !resume_valid);

    assert_masked_never_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> mask_hit);

    assert_vec_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    assert_vec_in_table_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> known);

    assert_entry_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> pend_hit);

    assert_plain_entry_lsb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !nest_q) |-> !ret_addr[0]);

    assert_single_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(vec_valid && resume_valid));

    assert_resume_even_R10: assert property (@(posedge clk) disable iff (!rst_n)
        resume_valid |-> !resume_addr[0]);

    assert_no_idle_return_R11: assert property (@(posedge clk) disable iff (!rst_n)
        resume_valid |-> ($past(pending) != '0));
endmodule

bind evt_nest_ctrl evt_nest_ctrl_chk #(
    .NUM_LVL  (NUM_LVL),
    .ADDR_W   (ADDR_W),
    .VEC_BASE (VEC_BASE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .vec_valid    (vec_valid),
    .vec_addr     (vec_addr),
    .pending      (pending),
    .mask_q       (mask_q),
    .nest_q       (nest_q),
    .ret_addr     (ret_addr),
    .resume_valid (resume_valid),
    .resume_addr  (resume_addr)
);

// File: tb/evt_nest_ctrl_test.sv
module evt_nest_ctrl_test;
    localparam int          NL   = 8;
    localparam int          AW   = 32;
    localparam logic [31:0] BASE = 32'h100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] raise_req = '0;
    logic          mask_we = 1'b0;
    logic [NL-1:0] mask_wdata = '0;
    logic          cfg_we = 1'b0;
    logic          cfg_nest = 1'b0;
    logic [AW-1:0] cur_pc = '0;
    logic          rti = 1'b0;
    logic          ret_we = 1'b0;
    logic [AW-1:0] ret_wdata = '0;
    logic [NL-1:0] latched, pending;
    logic          vec_valid, resume_valid;
    logic [AW-1:0] vec_addr, ret_addr, resume_addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    evt_nest_ctrl #(.NUM_LVL(NL), .ADDR_W(AW), .VEC_BASE(BASE)) uut (
        .clk(clk), .rst_n(rst_n), .raise_req(raise_req),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .cfg_we(cfg_we), .cfg_nest(cfg_nest), .cur_pc(cur_pc),
        .rti(rti), .ret_we(ret_we), .ret_wdata(ret_wdata),
        .latched(latched), .pending(pending),
        .vec_valid(vec_valid), .vec_addr(vec_addr), .ret_addr(ret_addr),
        .resume_valid(resume_valid), .resume_addr(resume_addr)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset;
        raise_req = '0; mask_we = 0; cfg_we = 0; rti = 0; ret_we = 0;
        rst_n = 0;
        tick; tick;
        rst_n = 1;
        tick;
    endtask

    task automatic set_mask(input logic [NL-1:0] m);
        mask_we = 1; mask_wdata = m; tick; mask_we = 0;
    endtask

    task automatic set_nest(input logic en);
        cfg_we = 1; cfg_nest = en; tick; cfg_we = 0;
    endtask

    task automatic raise(input int lvl);
        raise_req = NL'(1) << lvl; tick; raise_req = '0;
    endtask

    task automatic write_ret(input logic [31:0] v);
        ret_we = 1; ret_wdata = v; tick; ret_we = 0;
    endtask

    task automatic do_rti;
        rti = 1; tick; rti = 0;
    endtask

    initial begin
        logic [31:0] s0, s1, pa, pb, pc;
        do_reset;
        // R1: reset state
        chk("R1 latched", 32'(latched), 0);
        chk("R1 pending", 32'(pending), 0);
        chk("R1 ret_addr", ret_addr, 0);
        chk("R1 vec_valid", 32'(vec_valid), 0);
        chk("R1 resume_valid", 32'(resume_valid), 0);
        // R1/R2: mask is zero after reset, so a raise only latches
        raise(3);
        chk("R2 latch after raise", 32'(latched), 32'h8);
        for (int k = 0; k < 6; k++) begin
            chk("R1 reset mask blocks vector", 32'(vec_valid), 0);
            tick;
        end

        // R11: return with nothing pending
        do_reset;
        do_rti;
        chk("R11 no resume", 32'(resume_valid), 0);
        chk("R11 pending", 32'(pending), 0);
        tick;
        chk("R11 no resume later", 32'(resume_valid), 0);

        // R3/R4/R5/R6/R9: every ordered pair of levels raised together
        for (int a = 0; a < NL - 1; a++) begin
            for (int b = a + 1; b < NL; b++) begin
                do_reset;
                set_mask('1);
                pa = 32'h8000 + 32'(64 * (a * NL + b));
                cur_pc = pa;
                raise_req = (NL'(1) << a) | (NL'(1) << b); tick; raise_req = '0;
                chk("R2 both latched", 32'(latched), (32'h1 << a) | (32'h1 << b));
                tick;
                chk("R4 vec_valid first", 32'(vec_valid), 1);
                chk("R3 R4 lowest level first", vec_addr, BASE + 32'(4 * a));
                chk("R5 pending set", 32'(pending), 32'h1 << a);
                chk("R3 R5 other stays latched", 32'(latched), 32'h1 << b);
                chk("R6 ret_addr", ret_addr, pa);
                tick;
                chk("R4 single pulse", 32'(vec_valid), 0);
                tick;
                chk("R3 higher waits", 32'(vec_valid), 0);
                do_rti;
                chk("R9 resume pulse", 32'(resume_valid), 1);
                chk("R9 resume addr", resume_addr, pa);
                chk("R9 pending cleared", 32'(pending), 0);
                tick;
                tick;
                chk("R3 deferred level vectors", vec_addr, BASE + 32'(4 * b));
                chk("R3 deferred vec_valid", 32'(vec_valid), 1);
                chk("R5 latched drained", 32'(latched), 0);
                tick;
            end
        end

        // R2: masked level never vectors
        do_reset;
        set_mask(8'h02);
        raise_req = 8'h12; tick; raise_req = '0;
        tick;
        chk("R2 unmasked vectors", vec_addr, BASE + 32'd4);
        tick;
        do_rti;
        tick;
        for (int k = 0; k < 12; k++) begin
            chk("R2 masked never vectors", 32'(vec_valid), 0);
            tick;
        end
        chk("R2 masked stays latched", 32'(latched), 32'h10);

        // R7/R9/R10: three-deep self-nesting on each level
        for (int l = 0; l < NL; l++) begin
            do_reset;
            set_mask('1);
            set_nest(1);
            pa = 32'h4000 + 32'(256 * l);
            pb = pa + 32'h20;
            pc = pa + 32'h40;
            cur_pc = pa; raise(l); tick;
            chk("R6 first entry lsb clear", ret_addr, pa);
            tick; s0 = ret_addr;
            cur_pc = pb; raise(l); tick;
            chk("R7 nested vector", 32'(vec_valid), 1);
            chk("R7 nested addr", vec_addr, BASE + 32'(4 * l));
            chk("R7 nested ret lsb set", ret_addr, pb | 32'h1);
            chk("R7 pending kept", 32'(pending), 32'h1 << l);
            tick; s1 = ret_addr;
            cur_pc = pc; raise(l); tick;
            chk("R7 third ret", ret_addr, pc | 32'h1);
            tick;
            do_rti;
            chk("R10 resume drops lsb", resume_addr, pc);
            chk("R10 pending kept", 32'(pending), 32'h1 << l);
            tick;
            write_ret(s1);
            do_rti;
            chk("R10 second resume", resume_addr, pb);
            chk("R10 pending still", 32'(pending), 32'h1 << l);
            tick;
            write_ret(s0);
            do_rti;
            chk("R9 outer resume", resume_addr, pa);
            chk("R9 pending cleared", 32'(pending), 0);
            tick;
        end

        // R8: self-nesting off, active level raised again
        for (int l = 0; l < NL; l++) begin
            do_reset;
            set_mask('1);
            pa = 32'h6000 + 32'(16 * l);
            cur_pc = pa; raise(l); tick; tick;
            cur_pc = pa + 32'h8; raise(l);
            for (int k = 0; k < 4; k++) begin
                chk("R8 no self vector", 32'(vec_valid), 0);
                tick;
            end
            chk("R8 stays latched", 32'(latched), 32'h1 << l);
            do_rti;
            chk("R8 return clears pending", 32'(pending), 0);
            tick; tick;
            chk("R8 re-entry after return", 32'(vec_valid), 1);
            chk("R8 re-entry ret lsb clear", ret_addr, pa + 32'h8);
            tick;
        end

        // R12: preemption with nesting enabled, then R10 hand-written marker
        do_reset;
        set_mask('1);
        set_nest(1);
        cur_pc = 32'h7000; raise(6); tick; tick;
        cur_pc = 32'h7100; raise(2); tick;
        chk("R12 preempt addr", vec_addr, BASE + 32'd8);
        chk("R12 ret lsb clear", ret_addr, 32'h7100);
        chk("R12 both pending", 32'(pending), 32'h44);
        tick;
        do_rti;
        chk("R12 resume", resume_addr, 32'h7100);
        chk("R12 inner cleared", 32'(pending), 32'h40);
        tick;
        write_ret(32'h7201);
        do_rti;
        chk("R10 marker keeps pending", 32'(pending), 32'h40);
        chk("R10 marker resume", resume_addr, 32'h7200);
        tick;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule